// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block is the register front end of an I/O interrupt router with 24 interrupt inputs. Software reaches it over a 32-bit read/write bus that exposes only two locations: a selector register and a data window. The selector picks which internal register the window reaches. Behind the window are four things: an identifier register, a read-only version word, a read-only arbitration word, and a routing table with one 64-bit entry per input pin. Each entry is split into two dwords.

The block stores the table and applies the access rules. Two status bits in each entry can be changed only by the downstream delivery logic: a remote-acknowledge flag and a delivery-in-progress flag. The bus can read these bits but cannot change them. The whole table is exported as a flat vector that the delivery logic reads every cycle. The delivery logic changes the two status bits through a dedicated side port. The side port can be used in the same cycle as a bus access.

Top module: `intr_route_regfile`

## Requirements
- R1: Only bus address bits 7:0 are decoded. Offset 0x00 is the selector and offset 0x10 is the window. A read at any other offset returns 0, and a write there changes nothing. Address bits above 7 are ignored, so 0x100 aliases 0x00.
- R2: Selector writes store data bits 7:0. A selector read returns the stored byte in bits 7:0, with bits 31:8 zero.
- R3: Selector value 0 is the identifier register. Its 8-bit value sits in bits 31:24, and bits 23:0 read as zero.
- R4: Selector value 1 reads 0x00170011, where bits 23:16 hold the last entry number (23) and bits 7:0 hold the version 0x11. Selector value 2 reads 0. Writes to either one have no effect.
- R5: Selector values 0x10 to 0x3F reach the table. Entry number = (selector − 0x10)/2. An even selector reaches bits 31:0 of that entry and an odd selector reaches bits 63:32.
- R6: A bus write to an entry's low dword leaves bit 14 (remote-acknowledge) and bit 12 (delivery status) unchanged.
- R7: The delivery-mode field (bits 10:8) is stored as written, including codes 3'b011 and 3'b110. The vector field (bits 7:0) accepts any value, including 0.
- R8: A window read at selector 3 to 0x0F or at 0x40 and above returns 0xFFFFFFFF. Window writes there have no effect on any state.
- R9: After reset, the selector, the identifier and the read data are zero, and every entry is 0x0000_0000_0001_0000 (mask bit 16 set).
- R10: The side port writes bit 14 and/or bit 12 of the entry given by `side_idx`. When it does so in the same cycle as a bus write to that entry's low dword, the side-port values win for those two bits and the bus data is taken for the rest.
- R11: `tbl_flat[64*k +: 64]` shows entry k, updated on the clock edge that accepts the write.
- R12: `bus_rdata` is registered. It takes the addressed value on the edge where `bus_rd` is high and holds that value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte offset of the access; only bits 7:0 are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| side_idx | input | 5 | Entry number targeted by the side port |
| side_rirr_we | input | 1 | Write enable for bit 14 of the selected entry |
| side_rirr_val | input | 1 | Value for bit 14 |
| side_dst_we | input | 1 | Write enable for bit 12 of the selected entry |
| side_dst_val | input | 1 | Value for bit 12 |
| tbl_flat | output | 1536 | All 24 entries, entry k at bits 64k+63:64k |

## Verification
The window is driven through each selector class in turn: identifier, version, arbitration, even and odd table halves, and both unimplemented ranges. A decode slip between classes therefore shows up as a wrong constant, a stray 0xFFFFFFFF, or a lost write.

An all-ones write to an entry's low dword separates correct protection of bits 14 and 12 from a plain store. Writes using reserved delivery-mode codes and vector zero catch any filtering of the written value. A write that arrives in the same cycle as a side-port update tells apart which source owns the status bits. Address aliasing above bit 7, offsets other than 0x00 and 0x10, and rdata hold after non-read cycles are each tried directly.

// File: rtl/intr_route_pkg.sv
package intr_route_pkg;
  typedef enum logic [2:0] {
    SEL_ID, SEL_VER, SEL_ARB, SEL_TBL, SEL_NONE
  } sel_kind_e;

  localparam int RIRR_BIT  = 14;
  localparam int DSTAT_BIT = 12;
  localparam int MASK_BIT  = 16;
  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
endpackage

// File: rtl/intr_route_decode.sv
module intr_route_decode
  import intr_route_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter logic [7:0] TBL_BASE = 8'h10,
  localparam int        EW       = $clog2(NUM_PINS)
) (
  input  logic [7:0]    sel,
  output sel_kind_e     kind,
  output logic [EW-1:0] ent,
  output logic          hi
);
  localparam logic [8:0] TBL_END = 9'(TBL_BASE) + 9'(2 * NUM_PINS);

  logic [7:0] rel;

  always_comb begin
    rel = sel - TBL_BASE;
    ent = rel[EW:1];
    hi  = rel[0];
    if (sel == 8'd0)                                      kind = SEL_ID;
    else if (sel == 8'd1)                                 kind = SEL_VER;
    else if (sel == 8'd2)                                 kind = SEL_ARB;
    else if (sel >= TBL_BASE && {1'b0, sel} < TBL_END)    kind = SEL_TBL;
    else                                                  kind = SEL_NONE;
  end
endmodule

// File: rtl/intr_route_slot.sv
module intr_route_slot
  import intr_route_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        we_lo,
  input  logic        we_hi,
  input  logic [31:0] wdata,
  input  logic        rirr_we,
  input  logic        rirr_val,
  input  logic        dst_we,
  input  logic        dst_val,
  output logic [63:0] ent_q
);
  localparam logic [63:0] RST_VAL = 64'(1) << MASK_BIT;
  localparam logic [31:0] RO_MASK = (32'(1) << RIRR_BIT) | (32'(1) << DSTAT_BIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_q <= RST_VAL;
    end else begin
      if (we_hi) ent_q[63:32] <= wdata;
      if (we_lo) ent_q[31:0]  <= (wdata & ~RO_MASK) | (ent_q[31:0] & RO_MASK);
      // side port assignments come last so they own the status bits
      if (rirr_we) ent_q[RIRR_BIT]  <= rirr_val;
      if (dst_we)  ent_q[DSTAT_BIT] <= dst_val;
    end
  end
endmodule

// File: rtl/intr_route_regfile.sv
module intr_route_regfile
  import intr_route_pkg::*;
#(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 12,
  parameter int         ID_W     = 8,
  parameter logic [7:0] VERSION  = 8'h11,
  parameter logic [7:0] TBL_BASE = 8'h10,
  localparam int        EW       = $clog2(NUM_PINS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [EW-1:0]            side_idx,
  input  logic                     side_rirr_we,
  input  logic                     side_rirr_val,
  input  logic                     side_dst_we,
  input  logic                     side_dst_val,
  output logic [NUM_PINS*64-1:0]   tbl_flat
);
  localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_PINS - 1), 8'h00, VERSION};

  logic [7:0]      off;
  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  sel_kind_e       kind;
  logic [EW-1:0]   ent;
  logic            hi;
  logic            win_wr;
  logic [63:0]     ent_arr [NUM_PINS];
  logic [31:0]     win_val;
  logic [31:0]     rd_val;
  wire             unused_addr_hi = &{1'b0, bus_addr[ADDR_W-1:8]};

  assign off    = bus_addr[7:0];
  assign win_wr = bus_wr && (off == OFF_WIN);

  intr_route_decode #(.NUM_PINS(NUM_PINS), .TBL_BASE(TBL_BASE)) u_dec (
    .sel(sel_q), .kind(kind), .ent(ent), .hi(hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      id_q  <= '0;
    end else begin
      if (bus_wr && off == OFF_SEL) sel_q <= bus_wdata[7:0];
      if (win_wr && kind == SEL_ID) id_q <= bus_wdata[31 -: ID_W];
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_slot
    logic tbl_hit;
    logic side_hit;
    assign tbl_hit  = win_wr && (kind == SEL_TBL) && (ent == EW'(g));
    assign side_hit = (side_idx == EW'(g));

    intr_route_slot u_slot (
      .clk      (clk),
      .rst      (rst),
      .we_lo    (tbl_hit && !hi),
      .we_hi    (tbl_hit && hi),
      .wdata    (bus_wdata),
      .rirr_we  (side_hit && side_rirr_we),
      .rirr_val (side_rirr_val),
      .dst_we   (side_hit && side_dst_we),
      .dst_val  (side_dst_val),
      .ent_q    (ent_arr[g])
    );
    assign tbl_flat[g*64 +: 64] = ent_arr[g];
  end

  always_comb begin
    unique case (kind)
      SEL_ID:  win_val = {id_q, {(32 - ID_W){1'b0}}};
      SEL_VER: win_val = VER_WORD;
      SEL_ARB: win_val = '0;
      SEL_TBL: win_val = hi ? ent_arr[ent][63:32] : ent_arr[ent][31:0];
      default: win_val = '1;
    endcase
    if (off == OFF_SEL)      rd_val = {24'h0, sel_q};
    else if (off == OFF_WIN) rd_val = win_val;
    else                     rd_val = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_val;
  end
endmodule

// File: rtl/intr_route_chk.sv
module intr_route_chk #(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] TBL_BASE = 8'h10
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic                   bus_rd,
  input logic [31:0]            bus_rdata,
  input logic [7:0]             sel_q,
  input logic                   side_rirr_we,
  input logic                   side_dst_we,
  input logic [NUM_PINS*64-1:0] tbl_flat
);
  localparam logic [8:0] TBL_END = 9'(TBL_BASE) + 9'(2 * NUM_PINS);

  logic [7:0] off;
  logic       sel_unknown;
  assign off         = bus_addr[7:0];
  assign sel_unknown = ({1'b0, sel_q} >= TBL_END) || (sel_q > 8'd2 && sel_q < TBL_BASE);

  p_other_off_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off != 8'h00 && off != 8'h10) |=> (bus_rdata == 32'h0));

  p_sel_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 8'h00) |=> (bus_rdata[31:8] == 24'h0));

  p_arb_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 8'h10 && sel_q == 8'd2) |=> (bus_rdata == 32'h0));

  p_ro_bits_keep_r6: assert property (@(posedge clk) disable iff (rst)
    (!side_rirr_we && !side_dst_we) |=> ($stable(tbl_flat[14]) && $stable(tbl_flat[12])));

  p_unknown_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && off == 8'h10 && sel_unknown) |=> (bus_rdata == 32'hFFFF_FFFF));

  p_reset_mask_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (tbl_flat[63:0] == 64'h0000_0000_0001_0000));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd && !$past(rst)) |=> $stable(bus_rdata));
endmodule

bind intr_route_regfile intr_route_chk #(
  .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_addr     (bus_addr),
  .bus_rd       (bus_rd),
  .bus_rdata    (bus_rdata),
  .sel_q        (sel_q),
  .side_rirr_we (side_rirr_we),
  .side_dst_we  (side_dst_we),
  .tbl_flat     (tbl_flat)
);

// File: tb/test_intr_route_regfile.sv
module test_intr_route_regfile;
  localparam int NUM_PINS = 24;
  localparam int EW       = $clog2(NUM_PINS);
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic        rd;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 12'h000, 32'hFFFF_FF05, 32'h0, 4'd2},          // R2 selector write
    '{1'b1, 12'h000, 32'h0, 32'h0000_0005, 4'd2},          // R2 upper bits zero
    '{1'b0, 12'h000, 32'h0, 32'h0, 4'd3},
    '{1'b0, 12'h010, 32'hAB12_3456, 32'h0, 4'd3},          // R3 id write
    '{1'b1, 12'h010, 32'h0, 32'hAB00_0000, 4'd3},          // R3 id read
    '{1'b0, 12'h000, 32'h1, 32'h0, 4'd4},
    '{1'b0, 12'h010, 32'h1234_5678, 32'h0, 4'd4},          // R4 version write ignored
    '{1'b1, 12'h010, 32'h0, 32'h0017_0011, 4'd4},          // R4 version value
    '{1'b0, 12'h000, 32'h2, 32'h0, 4'd4},
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 32'h0, 4'd4},
    '{1'b1, 12'h010, 32'h0, 32'h0, 4'd4},                  // R4 arbitration zero
    '{1'b0, 12'h000, 32'h10, 32'h0, 4'd9},
    '{1'b1, 12'h010, 32'h0, 32'h0001_0000, 4'd9},          // R9 entry reset value
    '{1'b0, 12'h010, 32'hFFFF_FFFF, 32'h0, 4'd6},
    '{1'b1, 12'h010, 32'h0, 32'hFFFF_AFFF, 4'd6},          // R6 bits 14,12 kept
    '{1'b0, 12'h000, 32'h11, 32'h0, 4'd5},
    '{1'b0, 12'h010, 32'hFF00_0000, 32'h0, 4'd5},          // R5 odd = high dword
    '{1'b1, 12'h010, 32'h0, 32'hFF00_0000, 4'd5},
    '{1'b0, 12'h000, 32'h3E, 32'h0, 4'd7},
    '{1'b0, 12'h010, 32'h0000_0300, 32'h0, 4'd7},          // R7 mode 011, vector 0
    '{1'b1, 12'h010, 32'h0, 32'h0000_0300, 4'd7},
    '{1'b0, 12'h010, 32'h0000_0600, 32'h0, 4'd7},          // R7 mode 110
    '{1'b1, 12'h010, 32'h0, 32'h0000_0600, 4'd7},
    '{1'b0, 12'h000, 32'h40, 32'h0, 4'd8},
    '{1'b0, 12'h010, 32'h1234_5678, 32'h0, 4'd8},
    '{1'b1, 12'h010, 32'h0, 32'hFFFF_FFFF, 4'd8},          // R8 above table
    '{1'b0, 12'h000, 32'h0F, 32'h0, 4'd8},
    '{1'b0, 12'h010, 32'h1234_5678, 32'h0, 4'd8},
    '{1'b1, 12'h010, 32'h0, 32'hFFFF_FFFF, 4'd8},          // R8 gap below table
    '{1'b1, 12'h020, 32'h0, 32'h0, 4'd1},                  // R1 other offset reads 0
    '{1'b0, 12'h020, 32'h0, 32'h0, 4'd1},
    '{1'b1, 12'h000, 32'h0, 32'h0000_000F, 4'd1},          // R1 write at 0x20 ignored
    '{1'b0, 12'h100, 32'h10, 32'h0, 4'd1},                 // R1 alias to selector
    '{1'b1, 12'h110, 32'h0, 32'hFFFF_AFFF, 4'd1},          // R1 alias to window
    '{1'b1, 12'h004, 32'h0, 32'h0, 4'd1}
  };

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [11:0]            bus_addr = '0;
  logic                   bus_wr = 1'b0;
  logic                   bus_rd = 1'b0;
  logic [31:0]            bus_wdata = '0;
  logic [31:0]            bus_rdata;
  logic [EW-1:0]          side_idx = '0;
  logic                   side_rirr_we = 1'b0;
  logic                   side_rirr_val = 1'b0;
  logic                   side_dst_we = 1'b0;
  logic                   side_dst_val = 1'b0;
  logic [NUM_PINS*64-1:0] tbl_flat;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  intr_route_regfile i_intr_route_regfile (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .side_idx(side_idx),
    .side_rirr_we(side_rirr_we), .side_rirr_val(side_rirr_val),
    .side_dst_we(side_dst_we), .side_dst_val(side_dst_val), .tbl_flat(tbl_flat)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    logic [31:0] rv;
    logic        all_rst;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check("R9 rdata after reset", 64'(bus_rdata), 64'h0);
    all_rst = 1'b1;
    for (int k = 0; k < NUM_PINS; k++)
      if (tbl_flat[k*64 +: 64] !== ENT_RST) all_rst = 1'b0;
    check("R9 all entries masked", 64'(all_rst), 64'h1);
    bus_read(12'h000, rv);
    check("R9 selector zero", 64'(rv), 64'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) begin
        bus_read(VEC[i].addr, rv);
        check($sformatf("R%0d vector %0d", VEC[i].req, i), 64'(rv), 64'(VEC[i].exp));
      end else begin
        bus_write(VEC[i].addr, VEC[i].data);
      end
    end

    // R11 export reflects stored entries
    check("R11 entry 0 export", tbl_flat[0 +: 64], 64'hFF00_0000_FFFF_AFFF);
    check("R11 entry 23 export", tbl_flat[23*64 +: 64], 64'h0000_0000_0000_0600);
    // R8 unimplemented writes touched nothing
    check("R8 entry 12 untouched", tbl_flat[12*64 +: 64], ENT_RST);
    bus_write(12'h000, 32'h0);
    bus_read(12'h010, rv);
    check("R8 id unchanged", 64'(rv), 64'hAB00_0000);

    // R10 side port sets remote-acknowledge on entry 0
    @(negedge clk);
    side_idx = '0; side_rirr_we = 1'b1; side_rirr_val = 1'b1;
    @(negedge clk);
    side_rirr_we = 1'b0;
    check("R10 side set bit14", 64'(tbl_flat[14]), 64'h1);
    bus_write(12'h000, 32'h10);
    bus_read(12'h010, rv);
    check("R10 bus sees bit14", 64'(rv), 64'hFFFF_EFFF);

    // R10 same-cycle bus write and side update
    @(negedge clk);
    bus_addr = 12'h010; bus_wdata = 32'h0; bus_wr = 1'b1;
    side_idx = '0; side_dst_we = 1'b1; side_dst_val = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; side_dst_we = 1'b0;
    check("R10 merge with bus write", 64'(tbl_flat[31:0]), 64'h0000_5000);

    @(negedge clk);
    side_idx = EW'(5); side_rirr_we = 1'b1; side_rirr_val = 1'b1;
    @(negedge clk);
    side_rirr_we = 1'b0;
    check("R10 side on entry 5", tbl_flat[5*64 +: 64], ENT_RST | 64'h4000);
    check("R10 entry 0 not hit", 64'(tbl_flat[31:0]), 64'h0000_5000);

    // R12 rdata holds without a read
    bus_read(12'h000, rv);
    bus_write(12'h000, 32'h22);
    repeat (2) @(negedge clk);
    check("R12 rdata hold", 64'(bus_rdata), 64'h10);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule